// File: doc/BRIEF.md
# Command Queue Trigger Sequencer

This block decides when command entries leave a single command FIFO and go to a serial transmitter. It keeps a four-state queue status: idle, waiting for a trigger, triggered, and paused. The mode input selects one of three trigger sources, each in single-scan or continuous-scan form. The sources are a software trigger, a level-sensitive gate, and a rising-edge trigger. While the queue is triggered and the FIFO holds an entry, the block pops that entry and starts its transmission. It then waits for the transmitter's done pulse before it considers the next entry.

Each entry carries two control bits, end-of-queue and pause. A completed end-of-queue entry raises a status flag. In single-scan modes that entry also stops the queue until software arms it again. In continuous-scan modes the queue returns to waiting on its own. The pause bit stops the queue only in edge modes. In level modes the pause flag instead reports that a closed gate has taken the queue out of the triggered state. If the gate closes during a transmission, the queue reacts only once that transmission ends. Both flags are cleared by writing one, and each drives an interrupt request through its own enable.

The trigger input passes through a parameterised synchroniser before it is used. The command FIFO, the transmitter and the register decoding sit outside this block.

Top module: `cmdq_trig_seq`

## Requirements
- R1: Reset with `rst` high puts the queue in IDLE and drives these outputs low: `eoq_flag`, `pause_flag`, `eoq_irq`, `pause_irq`, `ss_status`, `tx_start` and `fifo_pop`. `q_state` encodes IDLE=0, WAIT=1, TRIG=2 and PAUSED=3.
- R2: `mode` encodes 0 off, 1 software single, 2 software continuous, 3 level single, 4 level continuous, 5 edge single, 6 edge continuous, 7 off. A change of `mode` returns the queue to IDLE and clears both flags and `ss_status` one cycle later.
- R3: `tx_start` and `fifo_pop` pulse together, and only while the queue is in TRIG with `fifo_nempty` high. After a `tx_start`, no further `tx_start` occurs until `tx_done` has been seen.
- R4: In a single-scan mode the queue leaves IDLE only after an `ss_arm` pulse, which sets `ss_status`. When an end-of-queue entry completes, `ss_status` clears and the queue goes to IDLE. No further entries are taken until the next `ss_arm`.
- R5: In a continuous-scan mode a completed end-of-queue entry returns the queue to WAIT with no software action. In software continuous mode the queue then retriggers by itself.
- R6: `eoq_flag` sets on the `tx_done` that completes an entry whose end-of-queue bit is 1. A one on `eoq_clr` clears it, and a set in the same cycle wins over the clear.
- R7: In edge modes, completing an entry whose pause bit is 1 stops transfers, enters PAUSED and sets `pause_flag`. A later rising edge on `trig_in` resumes with the next entry. If an entry has both bits set, its end-of-queue bit takes precedence.
- R8: In edge single-scan mode, setting `pause_flag` leaves `ss_status` set.
- R9: In software and level modes the pause bit of an entry has no effect. Such an entry never sets `pause_flag`, and transfers continue.
- R10: In level modes a high `trig_in` (gate open) moves WAIT to TRIG. A low gate seen in TRIG while no transmission is outstanding moves the queue to WAIT and sets `pause_flag`.
- R11: A gate that closes while a transmission is outstanding leaves the queue in TRIG until `tx_done`. At `tx_done` it moves the queue to WAIT and sets `pause_flag`.
- R12: `eoq_irq` equals `eoq_ie` AND `eoq_flag` from the previous cycle. `pause_irq` equals `pause_ie` AND `pause_flag` from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Trigger mode select |
| trig_in | input | 1 | Trigger edge or gate level, asynchronous |
| ss_arm | input | 1 | Single-scan arm pulse |
| fifo_nempty | input | 1 | Command FIFO holds at least one entry |
| head_eoq | input | 1 | End-of-queue bit of the FIFO head entry |
| head_pause | input | 1 | Pause bit of the FIFO head entry |
| fifo_pop | output | 1 | Remove the head entry from the FIFO |
| tx_start | output | 1 | Start transmitting the popped entry |
| tx_done | input | 1 | Transmission of the current entry finished |
| eoq_clr | input | 1 | Write-one-to-clear for the end-of-queue flag |
| pause_clr | input | 1 | Write-one-to-clear for the pause flag |
| eoq_ie | input | 1 | End-of-queue interrupt enable |
| pause_ie | input | 1 | Pause interrupt enable |
| q_state | output | 2 | Queue state |
| ss_status | output | 1 | Single-scan armed status |
| eoq_flag | output | 1 | End-of-queue status flag |
| pause_flag | output | 1 | Pause or gate-closed status flag |
| eoq_irq | output | 1 | End-of-queue interrupt request |
| pause_irq | output | 1 | Pause interrupt request |

## Verification
The bench builds the block with `SYNC_STAGES` = 3, one stage deeper than the default, so that the generated synchroniser chain is longer than its minimum. This delays every gate and edge by one more cycle. The bench's waits must therefore settle on queue states rather than exact edges. A transmitter latency of 40 cycles brings the deferred gate-close case within reach: the gate can be closed while a transmission is plainly still in flight. In the random phase the latency is kept at two or three cycles. That keeps a mode change from ever overlapping a new transfer, so the one-outstanding check stays meaningful across aborts.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    Q_IDLE  = 2'd0,
    Q_WAIT  = 2'd1,
    Q_TRIG  = 2'd2,
    Q_PAUSE = 2'd3
  } qstate_e;

  function automatic logic md_single(input logic [MODE_W-1:0] m);
    return (m == 3'd1) || (m == 3'd3) || (m == 3'd5);
  endfunction

  function automatic logic md_cont(input logic [MODE_W-1:0] m);
    return (m == 3'd2) || (m == 3'd4) || (m == 3'd6);
  endfunction

  function automatic logic md_level(input logic [MODE_W-1:0] m);
    return (m == 3'd3) || (m == 3'd4);
  endfunction

  function automatic logic md_edge(input logic [MODE_W-1:0] m);
    return (m == 3'd5) || (m == 3'd6);
  endfunction

  function automatic logic md_sw(input logic [MODE_W-1:0] m);
    return (m == 3'd1) || (m == 3'd2);
  endfunction

endpackage

// File: rtl/cmdq_trig_sync.sv
module cmdq_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_in,
  output logic level,
  output logic rise
);

  logic [STAGES-1:0] sh;
  logic              level_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= trig_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], trig_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) level_d <= 1'b0;
    else     level_d <= level;
  end

  assign level = sh[STAGES-1];
  assign rise  = level & ~level_d;

endmodule

// File: rtl/cmdq_xfer_ctrl.sv
module cmdq_xfer_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic abort,
  input  logic go,
  input  logic fifo_nempty,
  input  logic head_eoq,
  input  logic head_pause,
  input  logic tx_done,
  output logic issue,
  output logic busy,
  output logic done,
  output logic done_eoq,
  output logic done_pause,
  output logic tx_start,
  output logic fifo_pop
);

  logic eoq_q;
  logic pause_q;

  assign issue      = go & ~busy & fifo_nempty & ~abort;
  assign done       = busy & tx_done & ~abort;
  assign done_eoq   = eoq_q;
  assign done_pause = pause_q;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy     <= 1'b0;
      tx_start <= 1'b0;
      fifo_pop <= 1'b0;
      eoq_q    <= 1'b0;
      pause_q  <= 1'b0;
    end else begin
      tx_start <= issue;
      fifo_pop <= issue;
      if (issue) begin
        busy    <= 1'b1;
        eoq_q   <= head_eoq;
        pause_q <= head_pause;
      end else if (done) begin
        busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cmdq_queue_fsm.sv
module cmdq_queue_fsm
  import cmdq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic              ss_arm,
  input  logic              gate,
  input  logic              rise,
  input  logic              busy,
  input  logic              issue,
  input  logic              done,
  input  logic              done_eoq,
  input  logic              done_pause,
  input  logic              eoq_clr,
  input  logic              pause_clr,
  input  logic              eoq_ie,
  input  logic              pause_ie,
  output logic              abort,
  output logic [1:0]        q_state,
  output logic              ss_status,
  output logic              eoq_flag,
  output logic              pause_flag,
  output logic              eoq_irq,
  output logic              pause_irq
);

  logic [MODE_W-1:0] mode_q;
  qstate_e           state, st_n;
  logic              trig_ok;
  logic              eoq_set, pause_set, sss_clr;

  assign abort   = (mode != mode_q);
  assign q_state = state;

  always_comb begin
    if (md_level(mode_q))     trig_ok = gate;
    else if (md_edge(mode_q)) trig_ok = rise;
    else                      trig_ok = md_sw(mode_q);
  end

  always_comb begin
    st_n      = state;
    eoq_set   = 1'b0;
    pause_set = 1'b0;
    sss_clr   = 1'b0;
    unique case (state)
      Q_IDLE: begin
        if (md_cont(mode_q) || (md_single(mode_q) && ss_status)) st_n = Q_WAIT;
      end
      Q_WAIT: begin
        if (trig_ok) st_n = Q_TRIG;
      end
      Q_TRIG: begin
        if (done) begin
          if (done_eoq) begin
            eoq_set = 1'b1;
            if (md_single(mode_q)) begin
              st_n    = Q_IDLE;
              sss_clr = 1'b1;
            end else begin
              st_n = Q_WAIT;
            end
          end else if (done_pause && md_edge(mode_q)) begin
            st_n      = Q_PAUSE;
            pause_set = 1'b1;
          end else if (md_level(mode_q) && !gate) begin
            st_n      = Q_WAIT;
            pause_set = 1'b1;
          end
        end else if (md_level(mode_q) && !gate && !busy && !issue) begin
          st_n      = Q_WAIT;
          pause_set = 1'b1;
        end
      end
      Q_PAUSE: begin
        if (md_edge(mode_q) && rise) st_n = Q_TRIG;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= '0;
      state      <= Q_IDLE;
      ss_status  <= 1'b0;
      eoq_flag   <= 1'b0;
      pause_flag <= 1'b0;
      eoq_irq    <= 1'b0;
      pause_irq  <= 1'b0;
    end else begin
      mode_q    <= mode;
      eoq_irq   <= eoq_ie & eoq_flag;
      pause_irq <= pause_ie & pause_flag;
      if (abort) begin
        state      <= Q_IDLE;
        ss_status  <= 1'b0;
        eoq_flag   <= 1'b0;
        pause_flag <= 1'b0;
      end else begin
        state      <= st_n;
        ss_status  <= (ss_arm & md_single(mode_q)) | (ss_status & ~sss_clr);
        eoq_flag   <= eoq_set | (eoq_flag & ~eoq_clr);
        pause_flag <= pause_set | (pause_flag & ~pause_clr);
      end
    end
  end

endmodule

// File: rtl/cmdq_trig_seq.sv
module cmdq_trig_seq
  import cmdq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode,
  input  logic       trig_in,
  input  logic       ss_arm,
  input  logic       fifo_nempty,
  input  logic       head_eoq,
  input  logic       head_pause,
  output logic       fifo_pop,
  output logic       tx_start,
  input  logic       tx_done,
  input  logic       eoq_clr,
  input  logic       pause_clr,
  input  logic       eoq_ie,
  input  logic       pause_ie,
  output logic [1:0] q_state,
  output logic       ss_status,
  output logic       eoq_flag,
  output logic       pause_flag,
  output logic       eoq_irq,
  output logic       pause_irq
);

  logic gate, rise;
  logic abort, go;
  logic issue, busy, done, done_eoq, done_pause;

  assign go = (q_state == Q_TRIG);

  cmdq_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .trig_in (trig_in),
    .level   (gate),
    .rise    (rise)
  );

  cmdq_xfer_ctrl u_xfer (
    .clk         (clk),
    .rst         (rst),
    .abort       (abort),
    .go          (go),
    .fifo_nempty (fifo_nempty),
    .head_eoq    (head_eoq),
    .head_pause  (head_pause),
    .tx_done     (tx_done),
    .issue       (issue),
    .busy        (busy),
    .done        (done),
    .done_eoq    (done_eoq),
    .done_pause  (done_pause),
    .tx_start    (tx_start),
    .fifo_pop    (fifo_pop)
  );

  cmdq_queue_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .ss_arm     (ss_arm),
    .gate       (gate),
    .rise       (rise),
    .busy       (busy),
    .issue      (issue),
    .done       (done),
    .done_eoq   (done_eoq),
    .done_pause (done_pause),
    .eoq_clr    (eoq_clr),
    .pause_clr  (pause_clr),
    .eoq_ie     (eoq_ie),
    .pause_ie   (pause_ie),
    .abort      (abort),
    .q_state    (q_state),
    .ss_status  (ss_status),
    .eoq_flag   (eoq_flag),
    .pause_flag (pause_flag),
    .eoq_irq    (eoq_irq),
    .pause_irq  (pause_irq)
  );

endmodule

// File: rtl/cmdq_trig_seq_chk.sv
module cmdq_trig_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] mode,
  input logic       tx_start,
  input logic       tx_done,
  input logic       eoq_ie,
  input logic       pause_ie,
  input logic [1:0] q_state,
  input logic       ss_status,
  input logic       eoq_flag,
  input logic       pause_flag,
  input logic       eoq_irq,
  input logic       pause_irq
);

  logic       out_q;
  logic [2:0] mode_d;

  always_ff @(posedge clk) begin
    mode_d <= mode;
    if (rst || (mode != mode_d)) out_q <= 1'b0;
    else if (tx_start)           out_q <= 1'b1;
    else if (tx_done)            out_q <= 1'b0;
  end

  // R3
  one_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> !out_q);

  // R6
  eoq_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(eoq_flag) |-> $past(tx_done));

  // R2
  mode_clr_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) != $past(mode, 2)) |->
      (q_state == 2'd0 && !eoq_flag && !pause_flag && !ss_status));

  // R9
  sw_nopause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pause_flag) |-> !($past(mode) == 3'd1 || $past(mode) == 3'd2));

  // R8
  edge_ss_keep_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(pause_flag) && $past(mode) == 3'd5) |-> ss_status);

  // R12
  eoq_irq_chk: assert property (@(posedge clk) disable iff (rst)
    eoq_irq == $past(eoq_ie && eoq_flag));

  // R12
  pause_irq_chk: assert property (@(posedge clk) disable iff (rst)
    pause_irq == $past(pause_ie && pause_flag));

endmodule

bind cmdq_trig_seq cmdq_trig_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode       (mode),
  .tx_start   (tx_start),
  .tx_done    (tx_done),
  .eoq_ie     (eoq_ie),
  .pause_ie   (pause_ie),
  .q_state    (q_state),
  .ss_status  (ss_status),
  .eoq_flag   (eoq_flag),
  .pause_flag (pause_flag),
  .eoq_irq    (eoq_irq),
  .pause_irq  (pause_irq)
);

// File: tb/cmdq_trig_seq_tb.sv
`timescale 1ns/1ps
module cmdq_trig_seq_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] mode = 3'd0;
  logic       trig_in = 1'b0, ss_arm = 1'b0;
  logic       fifo_nempty, head_eoq, head_pause;
  logic       fifo_pop, tx_start;
  logic       tx_done = 1'b0;
  logic       eoq_clr = 1'b0, pause_clr = 1'b0, eoq_ie = 1'b0, pause_ie = 1'b0;
  logic [1:0] q_state;
  logic       ss_status, eoq_flag, pause_flag, eoq_irq, pause_irq;

  int nchk = 0, nfail = 0;
  int lat = 3, cnt = 0;
  int wr = 0, rd = 0, r0 = 0;
  logic fe [64];
  logic fp [64];
  logic [2:0] mode_prev = 3'd0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign fifo_nempty = (wr != rd);
  assign head_eoq    = fe[rd & 63];
  assign head_pause  = fp[rd & 63];

  cmdq_trig_seq #(.SYNC_STAGES(3)) u_dut (
    .clk(clk), .rst(rst), .mode(mode), .trig_in(trig_in), .ss_arm(ss_arm),
    .fifo_nempty(fifo_nempty), .head_eoq(head_eoq), .head_pause(head_pause),
    .fifo_pop(fifo_pop), .tx_start(tx_start), .tx_done(tx_done),
    .eoq_clr(eoq_clr), .pause_clr(pause_clr), .eoq_ie(eoq_ie), .pause_ie(pause_ie),
    .q_state(q_state), .ss_status(ss_status), .eoq_flag(eoq_flag),
    .pause_flag(pause_flag), .eoq_irq(eoq_irq), .pause_irq(pause_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input bit e, input bit p);
    fe[wr & 63] = e;
    fp[wr & 63] = p;
    wr++;
  endtask

  task automatic arm();
    ss_arm = 1'b1; tick(1); ss_arm = 1'b0;
  endtask

  task automatic edge_pulse();
    trig_in = 1'b1; tick(6); trig_in = 1'b0; tick(6);
  endtask

  function automatic bit sw_mode(input logic [2:0] m);
    return (m == 3'd1) || (m == 3'd2);
  endfunction

  // transmitter model, FIFO pointer and per-cycle monitors
  always @(negedge clk) begin
    if (rst) begin
      cnt = 0; tx_done = 1'b0;
    end else begin
      // R3: start and pop pulse together
      chk("R3 start/pop pair", int'(tx_start), int'(fifo_pop));
      // R9: no pause flag while a software mode has been stable
      if (mode == mode_prev && sw_mode(mode))
        chk("R9 no pause flag in software mode", int'(pause_flag), 0);
      mode_prev = mode;
      tx_done = 1'b0;
      if (cnt == 1) tx_done = 1'b1;
      if (cnt > 0) cnt--;
      if (tx_start) begin
        chk("R3 one outstanding transfer", cnt, 0);
        cnt = lat;
      end
      if (fifo_pop) rd++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) begin fe[i] = 1'b0; fp[i] = 1'b0; end
    tick(4);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    chk("R1 state", int'(q_state), 0);
    chk("R1 flags", int'({eoq_flag, pause_flag, ss_status}), 0);
    chk("R1 outputs", int'({tx_start, fifo_pop, eoq_irq, pause_irq}), 0);

    // software continuous: pause bit ignored, eoq flag and irq
    r0 = rd; eoq_ie = 1'b1;
    push(0, 0); push(0, 1); push(0, 0); push(1, 0);
    mode = 3'd2;
    tick(60);
    chk("R9 sw pause ignored pops", rd - r0, 4);
    chk("R9 sw pause flag", int'(pause_flag), 0);
    chk("R6 eoq flag set", int'(eoq_flag), 1);
    chk("R12 eoq irq", int'(eoq_irq), 1);
    chk("R5 sw continuous retrigger", int'(q_state), 2);
    eoq_clr = 1'b1; tick(1); eoq_clr = 1'b0; tick(2);
    chk("R6 eoq flag cleared", int'(eoq_flag), 0);
    chk("R12 eoq irq cleared", int'(eoq_irq), 0);

    // software single
    mode = 3'd0; tick(5);
    chk("R2 off mode idle", int'(q_state), 0);
    mode = 3'd1; r0 = rd;
    push(0, 0); push(0, 0); push(1, 0); push(0, 0); push(0, 0);
    tick(30);
    chk("R4 no arm no pop", rd - r0, 0);
    chk("R4 no arm idle", int'(q_state), 0);
    arm(); tick(60);
    chk("R4 stop at eoq", rd - r0, 3);
    chk("R4 idle after eoq", int'(q_state), 0);
    chk("R4 ss cleared", int'(ss_status), 0);
    chk("R6 eoq flag single", int'(eoq_flag), 1);
    arm(); tick(60);
    chk("R4 rearm resumes", rd - r0, 5);
    chk("R4 triggered after rearm", int'(q_state), 2);
    chk("R4 ss set", int'(ss_status), 1);

    // mode change clears
    mode = 3'd0; tick(3);
    chk("R2 change clears flags", int'({eoq_flag, pause_flag, ss_status}), 0);
    chk("R2 change idle", int'(q_state), 0);

    // edge single with pause
    mode = 3'd5; pause_ie = 1'b1; r0 = rd;
    push(0, 1); push(0, 0); push(1, 0);
    tick(2); arm(); tick(20);
    chk("R4 edge armed waiting", int'(q_state), 1);
    chk("R7 no edge no pop", rd - r0, 0);
    edge_pulse(); tick(30);
    chk("R7 pause stops", rd - r0, 1);
    chk("R7 paused state", int'(q_state), 3);
    chk("R7 pause flag", int'(pause_flag), 1);
    chk("R8 ss kept on pause", int'(ss_status), 1);
    chk("R12 pause irq", int'(pause_irq), 1);
    pause_clr = 1'b1; tick(1); pause_clr = 1'b0; tick(2);
    chk("R7 pause flag w1c", int'(pause_flag), 0);
    chk("R12 pause irq low", int'(pause_irq), 0);
    edge_pulse(); tick(30);
    chk("R7 edge resumes", rd - r0, 3);
    chk("R4 edge single idle", int'(q_state), 0);
    chk("R4 edge single ss clear", int'(ss_status), 0);

    // edge continuous, eoq+pause priority
    mode = 3'd6; r0 = rd;
    push(0, 0); push(1, 1); push(0, 0); push(1, 0);
    tick(20);
    chk("R5 edge cont waiting", int'(q_state), 1);
    edge_pulse(); tick(30);
    chk("R5 edge cont stops at eoq", rd - r0, 2);
    chk("R7 eoq wins over pause", int'(q_state), 1);
    chk("R7 eoq wins no pause flag", int'(pause_flag), 0);
    edge_pulse(); tick(30);
    chk("R5 edge cont next scan", rd - r0, 4);
    chk("R5 back to wait", int'(q_state), 1);

    // level continuous
    mode = 3'd4; r0 = rd;
    push(0, 1); push(0, 0); push(0, 0);
    tick(20);
    chk("R10 gate closed waits", int'(q_state), 1);
    trig_in = 1'b1; tick(50);
    chk("R9 level pause ignored pops", rd - r0, 3);
    chk("R9 level pause flag", int'(pause_flag), 0);
    chk("R10 gate open triggered", int'(q_state), 2);
    trig_in = 1'b0; tick(10);
    chk("R10 gate close to wait", int'(q_state), 1);
    chk("R10 gate close flag", int'(pause_flag), 1);
    pause_clr = 1'b1; tick(1); pause_clr = 1'b0;
    lat = 40; trig_in = 1'b1; tick(15);
    push(0, 0);
    for (int i = 0; i < 60 && !tx_start; i++) tick(1);
    trig_in = 1'b0; tick(12);
    chk("R11 still triggered mid transfer", int'(q_state), 2);
    chk("R11 no flag mid transfer", int'(pause_flag), 0);
    tick(50);
    chk("R11 wait after done", int'(q_state), 1);
    chk("R11 flag after done", int'(pause_flag), 1);
    lat = 3;
    mode = 3'd0; tick(10);

    // random phase
    for (int rnd = 0; rnd < 12; rnd++) begin
      lat = 2 + int'($urandom % 2);
      mode = 3'($urandom % 8);
      eoq_ie = 1'($urandom % 2);
      pause_ie = 1'($urandom % 2);
      for (int c = 0; c < 250; c++) begin
        if ($urandom % 8 == 0) trig_in = ~trig_in;
        ss_arm    = ($urandom % 40 == 0);
        eoq_clr   = ($urandom % 16 == 0);
        pause_clr = ($urandom % 16 == 0);
        if ((wr - rd) < 8 && ($urandom % 6 == 0))
          push(1'($urandom % 5 == 0), 1'($urandom % 4 == 0));
        tick(1);
      end
      ss_arm = 1'b0; eoq_clr = 1'b0; pause_clr = 1'b0;
    end
    mode = 3'd0; tick(6);
    chk("R2 final idle", int'(q_state), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule